// File: doc/BRIEF.md
# Packed Lane Shifter

This block is the shift unit of a 64-bit packed SIMD datapath. It treats the 64-bit operand as four 16-bit word lanes, two 32-bit doubleword lanes or one 64-bit quadword lane. It shifts every lane left logically, right logically or right arithmetically. No bit ever moves from one lane into a neighbouring lane. The shift amount comes from one of two places: the full 64-bit register count operand, or an 8-bit immediate. The opcode byte decides which of the two is used.

The opcode byte selects the lane size and the count source. For register-count opcodes it also fixes the shift kind. Each lane size has one immediate-count opcode, and for those opcodes bits [5:3] of the ModR/M byte pick the shift kind. The decoder flags any combination it does not recognise as illegal.

A small two-state machine drives the result timing. The states are IDLE and SHOW:
- IDLE goes to SHOW when `in_valid` is high.
- SHOW stays in SHOW when `in_valid` is high.
- SHOW returns to IDLE when `in_valid` is low.

`out_valid` is high only in SHOW. On every strobe, the result and the illegal flag are captured into registers.

Top module: `packed_lane_shifter`

## Requirements
- R1: Opcodes 0xF1, 0xF2 and 0xF3 shift word, doubleword and quadword lanes left logically by `count_reg`. Vacated bits are filled with zero.
- R2: Opcodes 0xD1, 0xD2 and 0xD3 shift word, doubleword and quadword lanes right logically by `count_reg`. Vacated bits are filled with zero.
- R3: Opcodes 0xE1 and 0xE2 shift word and doubleword lanes right arithmetically by `count_reg`. Vacated bits are filled with the lane's sign bit.
- R4: Opcodes 0x71, 0x72 and 0x73 are the immediate forms for word, doubleword and quadword lanes. The shift kind comes from `modrm[5:3]`: 2 is right logical, 4 is right arithmetic and 6 is left logical.
- R5: These cases raise `illegal` and give a result of zero:
  - an immediate form whose `modrm[5:3]` is not 2, 4 or 6;
  - opcode 0x73 with `modrm[5:3]` equal to 4;
  - any opcode not listed in R1 to R4.
- R6: The count is unsigned and all 64 bits of `count_reg` are used. A count at or above the lane width clears the lane for logical shifts and fills it with the sign bit for arithmetic shifts.
- R7: Immediate forms take the count from `imm` and ignore `count_reg`. Register forms ignore `imm`.
- R8: `out_valid`, `result` and `illegal` update on the clock edge that samples `in_valid` high. While `in_valid` is low, `out_valid` is low one cycle later and `result` and `illegal` hold their values.
- R9: After reset, `out_valid`, `result` and `illegal` are all zero.
- R10: Shifts stay inside their lanes. No lane's result depends on bits of another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe: the inputs below hold an operation |
| opcode | input | 8 | Second opcode byte |
| modrm | input | 8 | ModR/M byte; bits [5:3] select the kind for immediate forms |
| operand | input | 64 | Packed data to shift |
| count_reg | input | 64 | Register-supplied shift count |
| imm | input | 8 | Immediate shift count |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 64 | Shifted packed data |
| illegal | output | 1 | The captured operation was not a legal shift |

## Verification
A wrong decode shows up on the first `out_valid` after the strobe, because the decode sits on the path one register deep. The symptoms would be a wrong lane size, a wrong kind, or an illegal flag that is set when it should be clear or clear when it should be set. Lane-size mix-ups only become visible when a data pattern has bits near the lane edges. For that reason the stimulus puts distinct bytes in every lane and uses counts just below, at and far above each lane width, including counts whose only set bits lie above bit 31. If the state register were stuck, `out_valid` would be wrong in the cycle right after a strobe or right after an idle cycle. A missing hold would show as `result` changing during idle cycles.

// File: rtl/pls_pkg.sv
package pls_pkg;
    localparam int DATA_W  = 64;
    localparam int CNT_W   = 64;
    localparam int WORD_W  = 16;
    localparam int DWORD_W = 32;

    typedef enum logic [1:0] {
        SH_LEFT   = 2'd0,
        SH_RLOG   = 2'd1,
        SH_RARITH = 2'd2
    } shift_kind_t;

    typedef enum logic [1:0] {
        LN_WORD  = 2'd0,
        LN_DWORD = 2'd1,
        LN_QWORD = 2'd2
    } lane_size_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } pls_state_t;
endpackage

// File: rtl/pls_decode.sv
module pls_decode
    import pls_pkg::*;
(
    input  logic [7:0]  opcode,
    input  logic [7:0]  modrm,
    output logic        legal,
    output logic        use_imm,
    output shift_kind_t kind,
    output lane_size_t  size
);
    logic [2:0] sel;
    assign sel = modrm[5:3];

    always_comb begin
        legal   = 1'b1;
        use_imm = 1'b0;
        kind    = SH_LEFT;
        size    = LN_WORD;
        case (opcode)
            8'hF1: begin size = LN_WORD;  kind = SH_LEFT;   end
            8'hF2: begin size = LN_DWORD; kind = SH_LEFT;   end
            8'hF3: begin size = LN_QWORD; kind = SH_LEFT;   end
            8'hD1: begin size = LN_WORD;  kind = SH_RLOG;   end
            8'hD2: begin size = LN_DWORD; kind = SH_RLOG;   end
            8'hD3: begin size = LN_QWORD; kind = SH_RLOG;   end
            8'hE1: begin size = LN_WORD;  kind = SH_RARITH; end
            8'hE2: begin size = LN_DWORD; kind = SH_RARITH; end
            8'h71, 8'h72, 8'h73: begin
                use_imm = 1'b1;
                case (opcode[1:0])
                    2'd1:    size = LN_WORD;
                    2'd2:    size = LN_DWORD;
                    default: size = LN_QWORD;
                endcase
                case (sel)
                    3'd2:    kind = SH_RLOG;
                    3'd4:    kind = SH_RARITH;
                    3'd6:    kind = SH_LEFT;
                    default: legal = 1'b0;
                endcase
                if (opcode == 8'h73 && sel == 3'd4) legal = 1'b0;
            end
            default: legal = 1'b0;
        endcase
    end

    // R5
    always_comb begin
        if (legal && kind == SH_RARITH) begin
            q_arith_absent_chk: assert (size != LN_QWORD)
                else $error("quadword arithmetic shift decoded as legal");
        end
    end
endmodule

// File: rtl/pls_lane_shift.sv
module pls_lane_shift
    import pls_pkg::*;
#(
    parameter int W    = 16,
    parameter int CW   = 64
) (
    input  logic [W-1:0]  din,
    input  shift_kind_t   kind,
    input  logic [CW-1:0] cnt,
    output logic [W-1:0]  dout
);
    localparam int AW = $clog2(W);

    logic          over;
    logic [AW-1:0] amt;

    assign over = (cnt >= CW'(W));
    assign amt  = cnt[AW-1:0];

    always_comb begin
        unique case (kind)
            SH_LEFT:   dout = over ? '0 : (din << amt);
            SH_RLOG:   dout = over ? '0 : (din >> amt);
            SH_RARITH: dout = over ? {W{din[W-1]}} : W'($signed(din) >>> amt);
            default:   dout = '0;
        endcase
    end
endmodule

// File: rtl/packed_lane_shifter.sv
module packed_lane_shifter
    import pls_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  opcode,
    input  logic [7:0]  modrm,
    input  logic [63:0] operand,
    input  logic [63:0] count_reg,
    input  logic [7:0]  imm,
    output logic        out_valid,
    output logic [63:0] result,
    output logic        illegal
);
    localparam int N_WORD  = DATA_W / WORD_W;
    localparam int N_DWORD = DATA_W / DWORD_W;

    logic        dec_legal;
    logic        dec_imm;
    shift_kind_t dec_kind;
    lane_size_t  dec_size;

    pls_decode u_dec (
        .opcode  (opcode),
        .modrm   (modrm),
        .legal   (dec_legal),
        .use_imm (dec_imm),
        .kind    (dec_kind),
        .size    (dec_size)
    );

    logic [CNT_W-1:0] cnt;
    assign cnt = dec_imm ? CNT_W'(imm) : count_reg;

    logic [DATA_W-1:0] res_w, res_d, res_q;

    for (genvar g = 0; g < N_WORD; g++) begin : g_word
        pls_lane_shift #(.W(WORD_W), .CW(CNT_W)) u_ln (
            .din  (operand[g*WORD_W +: WORD_W]),
            .kind (dec_kind),
            .cnt  (cnt),
            .dout (res_w[g*WORD_W +: WORD_W])
        );
    end

    for (genvar g = 0; g < N_DWORD; g++) begin : g_dword
        pls_lane_shift #(.W(DWORD_W), .CW(CNT_W)) u_ln (
            .din  (operand[g*DWORD_W +: DWORD_W]),
            .kind (dec_kind),
            .cnt  (cnt),
            .dout (res_d[g*DWORD_W +: DWORD_W])
        );
    end

    pls_lane_shift #(.W(DATA_W), .CW(CNT_W)) u_qword (
        .din  (operand),
        .kind (dec_kind),
        .cnt  (cnt),
        .dout (res_q)
    );

    logic [DATA_W-1:0] res_sel;
    always_comb begin
        unique case (dec_size)
            LN_WORD:  res_sel = res_w;
            LN_DWORD: res_sel = res_d;
            LN_QWORD: res_sel = res_q;
            default:  res_sel = '0;
        endcase
        if (!dec_legal) res_sel = '0;
    end

    pls_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_SHOW;
            ST_SHOW: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result  <= '0;
            illegal <= 1'b0;
        end else if (in_valid) begin
            result  <= res_sel;
            illegal <= !dec_legal;
        end
    end

    assign out_valid = (state_q == ST_SHOW);

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(illegal)));
    // R5
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> (result == '0));
endmodule

// File: tb/packed_lane_shifter_test.sv
module packed_lane_shifter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  modrm = '0;
    logic [63:0] operand = '0;
    logic [63:0] count_reg = '0;
    logic [7:0]  imm = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [64:0] exp_q[$];
    string       tag_q[$];
    logic [64:0] last_exp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    packed_lane_shifter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .modrm(modrm), .operand(operand), .count_reg(count_reg), .imm(imm),
        .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    function automatic logic [64:0] model(input logic [7:0] op, input logic [7:0] md,
                                          input logic [63:0] a, input logic [63:0] cr,
                                          input logic [7:0] im);
        int w = 16; int k = 0; bit ok = 1; bit ui = 0; int cc; logic [63:0] c;
        logic [63:0] r = '0;
        case (op)
            8'hF1: begin w = 16; k = 0; end
            8'hF2: begin w = 32; k = 0; end
            8'hF3: begin w = 64; k = 0; end
            8'hD1: begin w = 16; k = 1; end
            8'hD2: begin w = 32; k = 1; end
            8'hD3: begin w = 64; k = 1; end
            8'hE1: begin w = 16; k = 2; end
            8'hE2: begin w = 32; k = 2; end
            8'h71, 8'h72, 8'h73: begin
                ui = 1;
                w = (op == 8'h71) ? 16 : (op == 8'h72) ? 32 : 64;
                case (md[5:3])
                    3'd2: k = 1;
                    3'd4: k = 2;
                    3'd6: k = 0;
                    default: ok = 0;
                endcase
                if (op == 8'h73 && k == 2) ok = 0;
            end
            default: ok = 0;
        endcase
        if (!ok) return {1'b1, 64'b0};
        c  = ui ? {56'b0, im} : cr;
        cc = (c >= 64'(w)) ? w : int'(c);
        for (int b = 0; b < 64; b++) begin
            int base = (b / w) * w;
            int p = b - base;
            case (k)
                0: r[b] = (p >= cc) ? a[b - cc] : 1'b0;
                1: r[b] = (p + cc < w) ? a[b + cc] : 1'b0;
                default: r[b] = (p + cc < w) ? a[b + cc] : a[base + w - 1];
            endcase
        end
        return {1'b0, r};
    endfunction

    task automatic send(input logic [7:0] op, input logic [7:0] md, input logic [63:0] a,
                        input logic [63:0] cr, input logic [7:0] im, input string tag);
        @(negedge clk);
        opcode = op; modrm = md; operand = a; count_reg = cr; imm = im;
        in_valid = 1'b1;
        exp_q.push_back(model(op, md, a, cr, im));
        tag_q.push_back(tag);
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            logic [64:0] e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8 out_valid with nothing pending actual %h expected none", result);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                last_exp = e;
                if ({illegal, result} !== e) begin
                    errors++;
                    $display("FAIL %s actual ill=%b res=%h expected ill=%b res=%h",
                             t, illegal, result, e[64], e[63:0]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [63:0] PAT  = 64'h8123_4567_F9AB_CDEF;
    localparam logic [63:0] PAT2 = 64'h7FFF_8001_0F0F_F0F0;

    initial begin
        repeat (2) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== '0 || illegal !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset actual v=%b r=%h i=%b expected 0 0 0", out_valid, result, illegal);
        end
        rst_n = 1'b1;

        send(8'hF1, 8'h00, PAT, 64'd4, 8'd99, "R1 word left by 4, R10 lanes");
        send(8'hF2, 8'h00, PAT, 64'd9, 8'd0, "R1 dword left by 9");
        send(8'hF3, 8'h00, PAT, 64'd63, 8'd0, "R1 qword left by 63");
        send(8'hD1, 8'h00, PAT, 64'd15, 8'd0, "R2 word right logical by 15");
        send(8'hD2, 8'h00, PAT, 64'd1, 8'd0, "R2 dword right logical by 1, R10");
        send(8'hD3, 8'h00, PAT, 64'd36, 8'd0, "R2 qword right logical by 36");
        send(8'hE1, 8'h00, PAT, 64'd3, 8'd0, "R3 word arith by 3");
        send(8'hE2, 8'h00, PAT2, 64'd31, 8'd0, "R3 dword arith by 31");
        send(8'hF1, 8'h00, PAT, 64'd16, 8'd0, "R6 word left count equals width");
        send(8'hE1, 8'h00, PAT, 64'd16, 8'd0, "R6 word arith count equals width");
        send(8'hD2, 8'h00, PAT, 64'h1_0000_0000, 8'd0, "R6 dword right count above bit 31");
        send(8'hE2, 8'h00, PAT, 64'h8000_0000_0000_0001, 8'd0, "R6 dword arith huge count");
        send(8'hF3, 8'h00, PAT, 64'd64, 8'd0, "R6 qword left count 64");
        send(8'h71, 8'h30, PAT, 64'd0, 8'd5, "R4 imm word left (reg 6), R7");
        send(8'h71, 8'h10, PAT, 64'd1, 8'd7, "R4 imm word right logical (reg 2)");
        send(8'h72, 8'h20, PAT, 64'd0, 8'd12, "R4 imm dword arith (reg 4)");
        send(8'h73, 8'hF0, PAT, 64'd0, 8'd8, "R4 imm qword left, mod bits set");
        send(8'h73, 8'h10, PAT, 64'd2, 8'd200, "R6 imm qword right count 200");
        send(8'h72, 8'h20, PAT, 64'd0, 8'd255, "R6 imm dword arith count 255");
        send(8'h71, 8'h30, PAT, 64'hFFFF_FFFF_FFFF_FFFF, 8'd1, "R7 count_reg ignored on imm form");
        send(8'hD1, 8'h00, PAT2, 64'd2, 8'hFF, "R7 imm ignored on reg form");
        send(8'h73, 8'h20, PAT, 64'd0, 8'd1, "R5 qword imm arith illegal");
        send(8'h71, 8'h08, PAT, 64'd0, 8'd1, "R5 imm reg field 1 illegal");
        send(8'h72, 8'h38, PAT, 64'd0, 8'd1, "R5 imm reg field 7 illegal");
        send(8'hE3, 8'h00, PAT, 64'd1, 8'd1, "R5 no quadword arith opcode");
        send(8'hFC, 8'h00, PAT, 64'd1, 8'd1, "R5 unrelated opcode");
        send(8'hD3, 8'h00, PAT2, 64'd0, 8'd0, "R2 qword count zero");

        @(negedge clk);
        in_valid = 1'b0;
        operand = '1; count_reg = 64'd3; opcode = 8'hF1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || {illegal, result} !== last_exp) begin
            errors++;
            $display("FAIL R8 idle hold actual v=%b r=%h expected v=0 r=%h",
                     out_valid, result, last_exp[63:0]);
        end

        send(8'h72, 8'h30, PAT2, 64'd0, 8'd31, "R8 strobe after idle");
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 pending results actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule